// File: doc/BRIEF.md
# Interrupt Priority Table Resolver

This block keeps a programmable table of forty priority slots and, every clock, works out which pending interrupt source is the most urgent. Each slot holds a source number and a valid flag. The slot's position in the table is its rank: slot 0 outranks slot 1, and so on down to slot 39. Sources are split into two classes by a steering vector. Sources whose steering bit is 1 belong to the fast class, and the rest belong to the normal class. Each class gets its own winner.

The surrounding controller supplies two inputs. The first is a vector of sources that are both pending and enabled. The second is the steering vector. Software programs the table through a small word-addressed port, and a table read returns the stored value combinationally. The block publishes one registered 32-bit result word. The fast-class winner is in the low half and the normal-class winner is in the high half, and each half has its own valid bit.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads back 0, and the result word is 0x003F003F.
- R2: A slot write stores only bit 31 (valid) and bits 5:0 (source number), with every other bit cleared. A read of that slot returns exactly the stored value.
- R3: Byte address 0x1C + 4k selects slot k for k in 0..31, and 0xB0 + 4(k-32) selects slot k for k in 32..39. Any other address, including an address that is not word aligned, changes no slot on write and reads as 0.
- R4: A slot takes part only when its bit 31 is 1 and its source number is below 40. Any other slot never produces a winner.
- R5: Within a class, the qualifying slot with the lowest index whose source is active wins. This holds even when two slots name sources of the same class.
- R6: A source whose steering bit is 1 competes in the fast class. Its result sits in bits 15 (valid) and 5:0 (source number).
- R7: A source whose steering bit is 0 competes in the normal class. Its result sits in bits 31 (valid) and 21:16 (source number).
- R8: A class with no winner reports valid 0 and source number 0x3F. Bits 30:22 and 14:6 are always 0.
- R9: The result word is registered. It reflects the table and the input vectors as they stood at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the table port |
| addr | input | 8 | Byte address for table reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the addressed slot |
| active_vec | input | 40 | Per-source pending-and-enabled flags |
| fiq_sel | input | 40 | Per-source class steering: 1 selects the fast class |
| hp_word | output | 32 | Registered winner word for both classes |

## Verification
The assertions assume that `active_vec` and `fiq_sel` hold steady across each rising edge, so the result can be related to their values one cycle earlier. They also assume that reset is held low through at least one clock edge before any check applies. The bench meets both assumptions: it changes every input only at the falling edge, and it holds reset for several cycles. The random part draws slot contents that include invalid slots, source numbers from 40 to 63 and stray upper bits. It then pairs those tables with random activity and steering vectors, so every qualifying rule is exercised within the legal input timing.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_SLOTS = 40,
  parameter int LO_SLOTS  = 32,
  parameter int ID_W      = 6,
  parameter int AW        = 8,
  parameter int LO_BASE   = 'h1C,
  parameter int HI_BASE   = 'hB0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [NUM_SLOTS-1:0] active_vec,
  input  logic [NUM_SLOTS-1:0] fiq_sel,
  output logic [31:0]          hp_word
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int SRC_SPACE = 1 << ID_W;
  localparam logic [31:0] KEEP = 32'h8000_0000 | 32'(SRC_SPACE - 1);
  localparam logic [ID_W-1:0] NONE_ID = '1;
  localparam int PAD = 15 - ID_W;
  localparam logic [31:0] IDLE_WORD = {1'b0, {PAD{1'b0}}, NONE_ID, 1'b0, {PAD{1'b0}}, NONE_ID};

  logic [NUM_SLOTS-1:0][31:0] slot_q;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [SRC_SPACE-1:0] act_x, fsel_x;
  logic             f_ok, i_ok;
  logic [ID_W-1:0]  f_id, i_id;

  function automatic int slot_addr(int k);
    return (k < LO_SLOTS) ? LO_BASE + 4 * k : HI_BASE + 4 * (k - LO_SLOTS);
  endfunction

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (int'(addr) == slot_addr(k)) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else if (wr_en && hit) slot_q[idx] <= wr_data & KEEP;
  end

  assign rd_data = hit ? slot_q[idx] : 32'h0;

  assign act_x  = SRC_SPACE'(active_vec);
  assign fsel_x = SRC_SPACE'(fiq_sel);

  always_comb begin
    logic [ID_W-1:0] sid;
    f_ok = 1'b0;
    i_ok = 1'b0;
    f_id = NONE_ID;
    i_id = NONE_ID;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      sid = slot_q[k][ID_W-1:0];
      if (slot_q[k][31] && int'(sid) < NUM_SLOTS && act_x[sid]) begin
        if (fsel_x[sid]) begin
          f_ok = 1'b1;
          f_id = sid;
        end else begin
          i_ok = 1'b1;
          i_id = sid;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hp_word <= IDLE_WORD;
    else        hp_word <= {i_ok, {PAD{1'b0}}, i_id, f_ok, {PAD{1'b0}}, f_id};
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NUM_SLOTS = 40
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [7:0]                addr,
  input logic [31:0]               wr_data,
  input logic [31:0]               rd_data,
  input logic [NUM_SLOTS-1:0]      active_vec,
  input logic [NUM_SLOTS-1:0]      fiq_sel,
  input logic [31:0]               hp_word,
  input logic [NUM_SLOTS*32-1:0]   slots
);
  p_write_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1C) |=> slots[31:0] == ($past(wr_data) & 32'h8000_003F));

  p_unmapped_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 8'h1C || addr[1:0] != 2'b00) |-> rd_data == 32'h0);

  p_fast_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[15] |-> ((($past(active_vec & fiq_sel)) >> hp_word[5:0]) & 40'd1) != 40'd0);

  p_normal_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[31] |-> ((($past(active_vec & ~fiq_sel)) >> hp_word[21:16]) & 40'd1) != 40'd0);

  p_fast_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_word[15] |-> hp_word[5:0] == 6'h3F);

  p_normal_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_word[31] |-> hp_word[21:16] == 6'h3F);

  p_zero_gaps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[30:22] == 9'h0 && hp_word[14:6] == 9'h0);

  p_nothing_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_vec) == '0 |-> hp_word == 32'h003F_003F);
endmodule

bind prio_resolver prio_resolver_chk #(.NUM_SLOTS(40)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .active_vec(active_vec), .fiq_sel(fiq_sel),
  .hp_word(hp_word), .slots(slot_q)
);

// File: tb/prio_resolver_test.sv
module prio_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic [N-1:0] active_vec = '0;
  logic [N-1:0] fiq_sel = '0;
  logic [31:0] hp_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .active_vec(active_vec), .fiq_sel(fiq_sel), .hp_word(hp_word)
  );

  function automatic logic [7:0] addr_of(int k);
    return (k < 32) ? 8'(28 + 4 * k) : 8'(176 + 4 * (k - 32));
  endfunction

  function automatic logic [31:0] exp_hp(logic [N-1:0] act, logic [N-1:0] fs);
    logic fv = 1'b0, iv = 1'b0;
    logic [5:0] fid = 6'h3F, iid = 6'h3F;
    for (int k = 0; k < N; k++) begin
      logic [5:0] s = model[k][5:0];
      if (model[k][31] && s < 6'd40 && act[s]) begin
        if (fs[s] && !fv) begin fv = 1'b1; fid = s; end
        if (!fs[s] && !iv) begin iv = 1'b1; iid = s; end
      end
    end
    return {iv, 9'h0, iid, fv, 9'h0, fid};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_slot(int k, logic [31:0] d);
    bus_write(addr_of(k), d);
    model[k] = d & 32'h8000_003F;
  endtask

  task automatic read_check(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic apply_and_check(string tag, logic [N-1:0] act, logic [N-1:0] fs);
    @(negedge clk);
    active_vec = act; fiq_sel = fs;
    @(negedge clk);
    check(tag, hp_word, exp_hp(act, fs));
  endtask

  task automatic clear_table();
    for (int k = 0; k < N; k++) put_slot(k, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < N; k++) model[k] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 result word", hp_word, 32'h003F_003F);
    for (int k = 0; k < N; k++) read_check("R1 slot reset", addr_of(k), 32'h0);

    // R2: masking on write at range edges
    put_slot(0, 32'hFFFF_FFFF);
    put_slot(31, 32'h7FFF_FFC5);
    put_slot(32, 32'hA5A5_A5A5);
    put_slot(39, 32'hFFFF_FFFF);
    read_check("R2 slot0", addr_of(0), 32'h8000_003F);
    read_check("R2 slot31", addr_of(31), 32'h0000_0005);
    read_check("R2 slot32", addr_of(32), 32'h8000_0025);
    read_check("R2 slot39", addr_of(39), 32'h8000_003F);

    // R3: unmapped and misaligned writes change nothing, read as 0
    bus_write(8'h00, 32'h8000_0001);
    bus_write(8'h18, 32'h8000_0002);
    bus_write(8'h9C, 32'h8000_0003);
    bus_write(8'h1E, 32'h8000_0004);
    bus_write(8'hD0, 32'h8000_0005);
    read_check("R3 read 0x00", 8'h00, 32'h0);
    read_check("R3 read 0x9C", 8'h9C, 32'h0);
    read_check("R3 read 0x1E", 8'h1E, 32'h0);
    read_check("R3 read 0xD0", 8'hD0, 32'h0);
    for (int k = 0; k < N; k++) read_check("R3 table intact", addr_of(k), model[k]);

    // R4: invalid slot and out-of-range source never win
    clear_table();
    put_slot(0, 32'h8000_002D);
    put_slot(1, 32'h0000_000C);
    put_slot(2, 32'h8000_0014);
    put_slot(3, 32'h8000_0007);
    apply_and_check("R4 qualify", '1, 40'h0);
    check("R4 normal winner", hp_word, 32'h8014_003F);
    apply_and_check("R4 fast qualify", '1, 40'h80);
    check("R4 fast winner", hp_word, 32'h8014_8007);

    // R5: slot order not source number; R6 and R7 class split
    clear_table();
    put_slot(3, 32'h8000_000A);
    put_slot(7, 32'h8000_0005);
    put_slot(9, 32'h8000_0021);
    apply_and_check("R5 order", (40'h1 << 10) | (40'h1 << 5), 40'h0);
    check("R5 low slot wins", hp_word, 32'h800A_003F);
    apply_and_check("R6 fast class", (40'h1 << 10) | (40'h1 << 5), 40'h1 << 5);
    check("R6 fast id", hp_word, 32'h800A_8005);
    apply_and_check("R7 normal only", 40'h1 << 33, 40'h0);
    check("R7 normal id", hp_word, 32'h8021_003F);

    // R8: nothing active
    apply_and_check("R8 idle", '0, '1);
    check("R8 idle word", hp_word, 32'h003F_003F);

    // R9: result lags inputs by one edge
    @(negedge clk);
    active_vec = 40'h1 << 5; fiq_sel = 40'h1 << 5;
    #1;
    check("R9 before edge", hp_word, 32'h003F_003F);
    @(negedge clk);
    check("R9 after edge", hp_word, 32'h003F_8005);

    // Random tables and vectors
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0) begin
        for (int k = 0; k < N; k++) begin
          logic [31:0] v = $urandom;
          if ($urandom_range(3) == 0) v[31] = 1'b0; else v[31] = 1'b1;
          put_slot(k, v);
        end
        read_check("R2 random readback", addr_of(it % N), model[it % N]);
      end
      begin
        logic [N-1:0] a = {$urandom, $urandom};
        logic [N-1:0] f = {$urandom, $urandom};
        if ($urandom_range(1) == 0) a = a & {$urandom, $urandom} & {$urandom, $urandom};
        apply_and_check("R5 R6 R7 random", a, f);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule